// File: doc/BRIEF.md
# Audio Master-Mode Clock Generator

This block generates the two serial-audio clocks that a converter drives when it acts as clock master. From an incoming master clock it produces a bit clock, a frame (left/right) clock whose rate is the sample rate, and a one-cycle strobe that marks the start of each frame. An optional divide-by-two prescale can be applied to the master clock first. All ratios are then taken from the resulting internal clock.

A two-bit speed select picks the frame length. A hardware-mode strap pins the generator to single speed. Every speed keeps 64 bit-clock periods per frame. Both output clocks are bits of one counter, so their edges always line up. New settings are taken only at a frame boundary, so a change never produces a shortened frame or a runt pulse.

Top module: `audio_mclk_divider`

## Requirements
- R1: When `div2_en` is 1, the internal clock advances on every second `mclk` cycle, so every output period is twice as long as with `div2_en` at 0.
- R2: With `speed_sel` = 00 (double speed), a frame lasts 128 internal cycles and `sclk` has a period of 2 internal cycles.
- R3: With `speed_sel` = 01 (single speed), a frame lasts 256 internal cycles and `sclk` has a period of 4 internal cycles.
- R4: With `speed_sel` = 10 (half speed), a frame lasts 512 internal cycles and `sclk` has a period of 8 internal cycles.
- R5: With `speed_sel` = 11 (quarter speed), a frame lasts 1024 internal cycles and `sclk` has a period of 16 internal cycles.
- R6: When `hw_strap` is 1, the generator runs at single speed (256 internal cycles per frame) whatever `speed_sel` holds, including when `speed_sel` changes while it runs.
- R7: `lrck` is low for the first half of each frame and high for the second half. Each frame holds exactly 64 `sclk` rising edges. Every `lrck` transition happens in the same `mclk` cycle as a falling edge of `sclk`.
- R8: `frame_start` is high for exactly one `mclk` cycle, and it is high exactly in the cycles where `lrck` has just fallen. No strobe is given for the frame that begins at reset release.
- R9: A change of `speed_sel`, `div2_en` or `hw_strap` in the middle of a frame does not alter that frame's length. The new setting governs from the next frame onward.
- R10: `rst_n` is a synchronous, active-low reset. While it is low and in the cycle after it is sampled low, `sclk`, `lrck` and `frame_start` are 0. The settings present during reset govern the first frame, which ends `N` internal cycles after release, where `N` is the frame length of those settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| div2_en | input | 1 | Halve the master clock before the ratio dividers |
| speed_sel | input | 2 | Speed mode: 00 double, 01 single, 10 half, 11 quarter |
| hw_strap | input | 1 | Force single speed and ignore `speed_sel` |
| sclk | output | 1 | Serial bit clock, 64 periods per frame |
| lrck | output | 1 | Frame clock at the sample rate, low in the first half of each frame |
| frame_start | output | 1 | One-cycle strobe in the cycle where `lrck` falls |

## Verification
The frame wrap and a settings change can fall in the same cycle: when a new speed or prescale is latched, the counter returns to zero in that cycle. The `lrck` fall, the `sclk` fall and the strobe must all be produced there from the new setting without a glitch. The bench provokes this by changing `speed_sel`, `div2_en` and `hw_strap` partway through a frame. It then measures the frame in progress and the frame after it separately. The frame in progress must keep the old length, the next frame must have the new length, and no `lrck` edge may occur away from an `sclk` fall at the changeover.

// File: rtl/audio_mclk_divider.sv
module audio_mclk_divider #(
  parameter int BASE_LOG2 = 7
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       div2_en,
  input  logic [1:0] speed_sel,
  input  logic       hw_strap,
  output logic       sclk,
  output logic       lrck,
  output logic       frame_start
);
  localparam int CW = BASE_LOG2 + 3;

  logic [1:0]    spd_q, spd_req, spd_nx;
  logic          div2_q, half_q, tick, wrap;
  logic [CW-1:0] cnt_q, cnt_nx, last_cnt, pos_sh;

  assign spd_req  = hw_strap ? 2'b01 : speed_sel;
  assign tick     = !div2_q || half_q;
  assign last_cnt = {CW{1'b1}} >> (2'd3 - spd_q);
  assign wrap     = tick && (cnt_q == last_cnt);
  assign spd_nx   = wrap ? spd_req : spd_q;
  assign cnt_nx   = wrap ? '0 : (tick ? cnt_q + 1'b1 : cnt_q);
  assign pos_sh   = cnt_nx >> spd_nx;

  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      spd_q       <= spd_req;
      div2_q      <= div2_en;
      half_q      <= 1'b0;
      sclk        <= 1'b0;
      lrck        <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      cnt_q       <= cnt_nx;
      spd_q       <= spd_nx;
      half_q      <= div2_q && !half_q;
      if (wrap) div2_q <= div2_en;
      sclk        <= pos_sh[0];
      lrck        <= pos_sh[BASE_LOG2-1];
      frame_start <= wrap;
    end
  end
endmodule

// File: rtl/audio_mclk_divider_chk.sv
module audio_mclk_divider_chk (
  input logic mclk,
  input logic rst_n,
  input logic sclk,
  input logic lrck,
  input logic frame_start
);
  a_r7_lrck_on_sclk_fall: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(lrck) |-> $fell(sclk));
  a_r8_strobe_on_lrck_fall: assert property (@(posedge mclk) disable iff (!rst_n)
    frame_start |-> $fell(lrck));
  a_r8_lrck_fall_has_strobe: assert property (@(posedge mclk) disable iff (!rst_n)
    $fell(lrck) |-> frame_start);
  a_r8_strobe_one_cycle: assert property (@(posedge mclk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  a_r10_reset_quiet: assert property (@(posedge mclk)
    !rst_n |=> (!sclk && !lrck && !frame_start));
endmodule

bind audio_mclk_divider audio_mclk_divider_chk i_chk (
  .mclk(mclk), .rst_n(rst_n), .sclk(sclk), .lrck(lrck), .frame_start(frame_start)
);

// File: tb/test_audio_mclk_divider.sv
`timescale 1ns/1ps
module test_audio_mclk_divider;
  logic mclk = 1'b0;
  logic rst_n = 1'b0;
  logic div2_en = 1'b0;
  logic [1:0] speed_sel = 2'b00;
  logic hw_strap = 1'b0;
  logic sclk, lrck, frame_start;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // div2, hw, speed, frame length in mclk cycles
  localparam int VEC [10][4] = '{
    '{0, 0, 0, 128},  '{0, 0, 1, 256},  '{0, 0, 2, 512},  '{0, 0, 3, 1024},
    '{1, 0, 0, 256},  '{1, 0, 1, 512},  '{1, 0, 2, 1024}, '{1, 0, 3, 2048},
    '{0, 1, 0, 256},  '{1, 1, 3, 512}
  };

  audio_mclk_divider i_audio_mclk_divider (
    .mclk(mclk), .rst_n(rst_n), .div2_en(div2_en), .speed_sel(speed_sel),
    .hw_strap(hw_strap), .sclk(sclk), .lrck(lrck), .frame_start(frame_start)
  );

  always #4 mclk = ~mclk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge mclk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string tag(int d, int h, int s);
    if (h != 0) return "R6";
    if (d != 0) return "R1";
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic do_reset(logic d, logic h, logic [1:0] s);
    @(negedge mclk);
    rst_n = 1'b0; div2_en = d; hw_strap = h; speed_sel = s;
    repeat (3) @(negedge mclk);
    check("R10", "sclk in reset", int'(sclk), 0);
    check("R10", "lrck in reset", int'(lrck), 0);
    check("R10", "frame_start in reset", int'(frame_start), 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_fs();
    int n = 0;
    do begin @(negedge mclk); n++; end while (!frame_start && n < 5000);
    if (n >= 5000) check("R8", "frame_start seen", 0, 1);
  endtask

  // starts on a sample where frame_start is high; ends on the next one
  task automatic measure(input int chg_at, input logic [1:0] nspd, input logic nd,
                         input logic nh, output int len, output int hi,
                         output int rises, output int shi, output int mis,
                         output int fsbad);
    logic pl, ps;
    pl = lrck; ps = sclk;
    len = 0; hi = 0; rises = 0; shi = 0; mis = 0; fsbad = 0;
    do begin
      @(negedge mclk);
      len++;
      if (len == chg_at) begin speed_sel = nspd; div2_en = nd; hw_strap = nh; end
      hi += int'(lrck);
      shi += int'(sclk);
      if (sclk && !ps) rises++;
      if (lrck != pl && !(ps && !sclk)) mis++;
      if (frame_start != (pl && !lrck)) fsbad++;
      pl = lrck; ps = sclk;
    end while (!frame_start && len < 5000);
  endtask

  initial begin
    int len, hi, rises, shi, mis, fsbad;

    for (int v = 0; v < 10; v++) begin
      string t;
      t = tag(VEC[v][0], VEC[v][1], VEC[v][2]);
      do_reset(VEC[v][0] != 0, VEC[v][1] != 0, 2'(VEC[v][2]));
      wait_fs();
      measure(-1, 2'(VEC[v][2]), VEC[v][0] != 0, VEC[v][1] != 0,
              len, hi, rises, shi, mis, fsbad);
      check(t, "frame length", len, VEC[v][3]);
      check(t, "sclk high cycles", shi, VEC[v][3] / 2);
      check("R7", "lrck high cycles", hi, VEC[v][3] / 2);
      check("R7", "sclk rises per frame", rises, 64);
      check("R7", "lrck edges off sclk fall", mis, 0);
      check("R8", "strobe mismatches", fsbad, 0);
    end

    // R10: first frame after release, no strobe at release
    do_reset(1'b0, 1'b0, 2'b00);
    len = 0;
    do begin @(negedge mclk); len++; end while (!frame_start && len < 5000);
    check("R10", "first frame length", len, 128);
    do_reset(1'b1, 1'b0, 2'b00);
    len = 0;
    do begin @(negedge mclk); len++; end while (!frame_start && len < 5000);
    check("R10", "first frame length with prescale", len, 256);

    // R9: speed change mid-frame
    do_reset(1'b0, 1'b0, 2'b00);
    wait_fs();
    measure(10, 2'b10, 1'b0, 1'b0, len, hi, rises, shi, mis, fsbad);
    check("R9", "frame during speed change", len, 128);
    check("R9", "edges off sclk fall at change", mis, 0);
    measure(-1, 2'b10, 1'b0, 1'b0, len, hi, rises, shi, mis, fsbad);
    check("R9", "frame after speed change", len, 512);
    check("R9", "sclk rises after change", rises, 64);
    check("R9", "edges off sclk fall after change", mis, 0);

    // R9 / R1: prescale enabled mid-frame
    measure(7, 2'b10, 1'b1, 1'b0, len, hi, rises, shi, mis, fsbad);
    check("R9", "frame during prescale change", len, 512);
    measure(-1, 2'b10, 1'b1, 1'b0, len, hi, rises, shi, mis, fsbad);
    check("R1", "frame after prescale on", len, 1024);
    check("R1", "lrck high after prescale on", hi, 512);
    check("R8", "strobe mismatches after prescale on", fsbad, 0);

    // R6: speed select ignored under hardware strap
    do_reset(1'b0, 1'b1, 2'b00);
    wait_fs();
    measure(20, 2'b11, 1'b0, 1'b1, len, hi, rises, shi, mis, fsbad);
    check("R6", "strap frame during speed change", len, 256);
    measure(-1, 2'b11, 1'b0, 1'b1, len, hi, rises, shi, mis, fsbad);
    check("R6", "strap frame after speed change", len, 256);
    check("R6", "strap sclk high cycles", shi, 128);

    // R9: strap released mid-frame, quarter speed follows
    measure(30, 2'b11, 1'b0, 1'b0, len, hi, rises, shi, mis, fsbad);
    check("R9", "frame during strap release", len, 256);
    measure(-1, 2'b11, 1'b0, 1'b0, len, hi, rises, shi, mis, fsbad);
    check("R5", "frame after strap release", len, 1024);
    check("R7", "edges off sclk fall after release", mis, 0);

    summary();
    $finish;
  end
endmodule